// File: doc/BRIEF.md
# Prioritized UART Interrupt Identification Encoder

This block gathers the seven interrupt causes of a UART channel and reduces them to one identification byte that the host reads to find out why the channel interrupted. Each cause arrives as a one-cycle request pulse. The pulse sets a pending flag, and the flag stays set until that cause's own clear strobe arrives. A per-source enable bit decides whether a pending flag can be reported. Of the flags that are both pending and enabled, the one with the highest priority supplies the 6-bit code. The two extended causes are reported only while the enhanced-function bit is set. These are software flow-control character detection and a flow-control pin going inactive.

The identification byte is built from the registered pending flags each cycle. A request sampled at a clock edge appears in the byte straight after that edge. A higher-priority cause that becomes pending replaces the current code on the next edge. Bit 0 of the byte is low while anything is reported, and the interrupt request output is its inverse. Bits 7:6 both copy the FIFO-enable control input.

Top module: `uart_irq_id`

## Requirements
- R1: After reset, or whenever no source is both pending and enabled, the byte's bits 5:0 read 000001 and irq_o is low.
- R2: Source index i: a pulse on req_i[i] sets its pending flag at the next edge. The flag holds until clr_i[i] is sampled high. A request and a clear in the same cycle leave the flag set. The active-low asynchronous reset clears all flags.
- R3: A pending source whose ien_i bit is low is not reported. It stays pending and is reported once enabled.
- R4: Line status error (index 0) has the highest priority and code 000110.
- R5: Receive timeout (index 1, code 001100) and receive data ready (index 2, code 000100) form the second level. Timeout wins when both are reported.
- R6: Transmit holding empty (index 3) reports 000010. Modem status change (index 4) reports 000000. Each ranks below all lower indices.
- R7: Flow-control character detection (index 5, code 010000) outranks flow-control pin deassertion (index 6, code 100000). Both are reported only when enh_en_i is high, so bits 5:4 are 00 while it is low.
- R8: Bits 7 and 6 of iid_o both equal fifo_en_i.
- R9: irq_o is the inverse of iid_o bit 0.
- R10: The code is re-evaluated every cycle. A newly pending higher-priority source replaces the current code on the edge that samples its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 7 | Per-source request pulses, index = priority order |
| clr_i | input | 7 | Per-source clear strobes |
| ien_i | input | 7 | Per-source report enables |
| fifo_en_i | input | 1 | FIFO-enable control bit, mirrored in bits 7:6 |
| enh_en_i | input | 1 | Enhanced-function enable, gates indices 5 and 6 |
| iid_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request, high when a source is reported |

## Verification
The assertions assume that request and clear strobes are sampled only at clock edges. They also assume the enable, FIFO-enable and enhanced-enable inputs change only between edges, so the combinational byte is stable whenever it is sampled. The bench drives every input on the falling edge and reads the byte before the next falling edge. Random stimulus keeps the request and clear pulses sparse, so pending flags build up over several cycles before they clear. This exercises overlapping priorities rather than single isolated sources.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC   = 7;
  localparam int CODE_W    = 6;
  localparam int ENH_FIRST = 5;  // indices at or above this need enh_en
  localparam logic [CODE_W-1:0] IDLE_CODE = 6'b000001;

  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      0:       return 6'b000110;
      1:       return 6'b001100;
      2:       return 6'b000100;
      3:       return 6'b000010;
      4:       return 6'b000000;
      5:       return 6'b010000;
      6:       return 6'b100000;
      default: return IDLE_CODE;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_pend_bit.sv
module uart_irq_pend_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else         pend_o <= set_i | (pend_o & ~clr_i);  // set wins
  end

  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o);
  assert_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_o);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> pend_o == $past(pend_o));
endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] act_i,
  output logic [CODE_W-1:0]  code_o
);
  logic [NUM_SRC-1:0] grant;
  logic               found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!found && act_i[i]) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    code_o = found ? '0 : IDLE_CODE;
    for (int i = 0; i < NUM_SRC; i++)
      if (grant[i]) code_o = code_o | src_code(i);
  end

  assert_onehot_grant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == '0) |-> code_o == IDLE_CODE);
  assert_top_prio_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i[0] |-> code_o == 6'b000110);
  assert_tmo_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i[1] |-> code_o != 6'b000100);
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] ien_i,
  input  logic               fifo_en_i,
  input  logic               enh_en_i,
  output logic [7:0]         iid_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] allow;
  logic [NUM_SRC-1:0] act;
  logic [CODE_W-1:0]  code;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    uart_irq_pend_bit u_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (req_i[g]),
      .clr_i  (clr_i[g]),
      .pend_o (pend[g])
    );
    if (g >= ENH_FIRST) begin : g_enh
      assign allow[g] = ien_i[g] & enh_en_i;
    end else begin : g_std
      assign allow[g] = ien_i[g];
    end
  end

  assign act = pend & allow;

  uart_irq_prio_enc u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .code_o (code)
  );

  assign iid_o = {fifo_en_i, fifo_en_i, code};
  assign irq_o = ~code[0];

  assert_mirror_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iid_o[7] == fifo_en_i && iid_o[6] == fifo_en_i);
  assert_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o != iid_o[0]);
  assert_enh_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enh_en_i |-> iid_o[5:4] == 2'b00);
  assert_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & ien_i) == '0) |-> iid_o[0]);
endmodule

// File: tb/sim_uart_irq_id.sv
`timescale 1ns/1ps
module sim_uart_irq_id;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] req_i = '0, clr_i = '0, ien_i = '0;
  logic       fifo_en_i = 1'b0, enh_en_i = 1'b0;
  logic [7:0] iid_o;
  logic       irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [6:0] m_pend = '0;

  always #2.5 clk_i = ~clk_i;

  uart_irq_id u0 (.*);

  function automatic logic [5:0] code_of(input int i);
    case (i)
      0: return 6'b000110;  1: return 6'b001100;  2: return 6'b000100;
      3: return 6'b000010;  4: return 6'b000000;  5: return 6'b010000;
      default: return 6'b100000;
    endcase
  endfunction

  function automatic logic [7:0] exp_iid(input logic [6:0] p, input logic [6:0] en,
                                         input logic enh, input logic fe);
    for (int i = 0; i < 7; i++)
      if (p[i] && en[i] && (i < 5 || enh)) return {fe, fe, code_of(i)};
    return {fe, fe, 6'b000001};
  endfunction

  task automatic chk(input string tag);
    logic [7:0] e;
    e = exp_iid(m_pend, ien_i, enh_en_i, fifo_en_i);
    checks++;
    if (iid_o !== e || irq_o !== ~e[0]) begin
      errors++;
      $display("FAIL %s iid=%b irq=%b expected iid=%b irq=%b", tag, iid_o, irq_o, e, ~e[0]);
    end
  endtask

  // drive at negedge, sample edge, check before next negedge
  task automatic step(input logic [6:0] rq, input logic [6:0] cl, input string tag);
    req_i = rq; clr_i = cl;
    @(posedge clk_i);
    m_pend = rq | (m_pend & ~cl);
    #1;
    chk(tag);
    @(negedge clk_i);
    req_i = '0; clr_i = '0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    ien_i = 7'h7f;
    repeat (2) @(negedge clk_i);
    chk("R1 reset idle");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after reset");
    fifo_en_i = 1'b1; #1; chk("R8 fifo mirror high");

    // single sources, R6 low end first
    step(7'b0010000, '0, "R6 modem");
    step(7'b0001000, '0, "R6 thr over modem");
    step(7'b0000100, '0, "R5 rx data");
    step(7'b0000010, '0, "R5 timeout beats rx data");
    step(7'b0000001, '0, "R4 line status top R10");
    step('0, 7'b0000001, "R2 clear lsr");
    step(7'b0000010, 7'b0000010, "R2 set wins over clear");
    step('0, 7'b0000010, "R5 rx data after timeout clr");
    step('0, 7'b0011110, "R1 all cleared");
    // masking
    step(7'b0000100, '0, "R2 set rx data");
    ien_i = 7'b1111011; #1; chk("R3 masked not reported");
    @(negedge clk_i); chk("R3 still pending masked");
    ien_i = 7'h7f; #1; chk("R3 reported once enabled");
    step('0, 7'b0000100, "R1 idle again");
    // enhanced sources
    enh_en_i = 1'b0;
    step(7'b1100000, '0, "R7 gated without enh");
    enh_en_i = 1'b1; #1; chk("R7 xoff with enh");
    step('0, 7'b0100000, "R7 pin deassert");
    step(7'b0010000, '0, "R10 modem replaces pin");
    step('0, 7'b1010000, "R1 idle enh");
    fifo_en_i = 1'b0; #1; chk("R8 fifo mirror low");

    // mid-run async reset
    step(7'b0001001, '0, "R2 pre reset");
    rst_ni = 1'b0; m_pend = '0; #1; chk("R2 async reset clears");
    @(negedge clk_i); rst_ni = 1'b1;

    for (int n = 0; n < 600; n++) begin
      logic [6:0] rq, cl;
      rq = 7'($urandom) & 7'($urandom) & 7'($urandom);
      cl = 7'($urandom) & 7'($urandom);
      if (n % 16 == 0) begin
        ien_i = 7'($urandom) | 7'($urandom);
        enh_en_i = 1'($urandom);
        fifo_en_i = 1'($urandom);
      end
      step(rq, cl, "R10 random mix");
    end
    finish_run();
  end
endmodule